// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block gathers the interrupt-worthy events of a USB device controller into a single byte-wide flag register. The events are bus reset, setup packet arrival, control-endpoint transfer events, and a transfer request on the bulk-in endpoint. Two further bits are not latched events. They mirror the live state of the double-buffered bulk-out and bulk-in FIFOs. Firmware reads the flags through a small register port and acknowledges an event by writing 0 to its bit. Writing 1 leaves a bit alone, so several flags can be acknowledged in one write without a read-modify-write race.

An enable byte and a line-select byte sit beside the flag byte. A flag that is set and enabled drives one of two level-sensitive interrupt request lines. Its select bit chooses the line: 0 picks line 0 and 1 picks line 1. A line stays high until firmware clears the flag or removes the enable. The event inputs come from the protocol engine and the endpoint FIFO logic. They are single-cycle pulses, except for the buffer state levels.

Top module: `usbdev_irq_flags`

## Requirements
- R1: After a synchronous reset, the flag, enable and select registers all read 0x00, and both interrupt lines are low.
- R2: A one-cycle pulse on `usb_bus_reset` sets flag bit 7. The bit is visible on the clock edge that samples the pulse.
- R3: Flag bit 6 reads 1 whenever either bit of `bulk_out_full` is 1. It reads 0 only when both bits are 0. It follows the inputs with one register stage.
- R4: Flag bit 5 sets when `bulk_in_token` is high while both bits of `bulk_in_empty` are 1. A token that arrives while either bulk-in buffer holds data leaves bit 5 unchanged.
- R5: Flag bit 4 reads 1 exactly when both bits of `bulk_in_empty` are 1. It follows the inputs with one register stage.
- R6: Pulses on `ctl_setup_rcvd`, `ctl_in_done`, `ctl_out_done` and `ctl_in_req` set flag bits 3, 2, 1 and 0, respectively.
- R7: A write to address 0 clears each of bits 7, 5, 3, 2, 1 and 0 whose written data bit is 0. A data bit of 1 leaves the flag unchanged.
- R8: Writes to address 0 never change bits 6 and 4. Those two bits always show the FIFO state.
- R9: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: Address 1 is the enable register and address 2 is the select register. Both are plain read/write bytes. Address 3 reads 0x00. Reads are combinational on `reg_addr`.
- R11: `irq_out[k]` is high exactly when some flag bit is 1, its enable bit is 1, and its select bit equals k. The line is a level that drops once the flag is cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 flags, 1 enable, 2 select) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| usb_bus_reset | input | 1 | Bus reset detected pulse |
| ctl_setup_rcvd | input | 1 | Setup packet received pulse |
| ctl_in_done | input | 1 | Control-IN transfer complete pulse |
| ctl_out_done | input | 1 | Control-OUT data received pulse |
| ctl_in_req | input | 1 | Control-IN transfer request pulse |
| bulk_in_token | input | 1 | IN token addressed to the bulk-in endpoint |
| bulk_in_empty | input | 2 | Empty state of the two bulk-in buffers |
| bulk_out_full | input | 2 | Full state of the two bulk-out buffers |
| irq_out | output | 2 | Interrupt request lines 0 and 1 |

## Verification
The collision that matters is a hardware event and a firmware acknowledge write landing on the same flag in the same clock. The bench provokes it by raising `ctl_setup_rcvd` in the same cycle that it writes 0x00 to the flag register. It then expects bit 3 to read back as 1 while every other clearable bit reads 0. In the same way, the bench writes 0 over the two status bits while the FIFO inputs hold them high. It expects those bits to keep following the inputs. A behavioural model compares the read data and both interrupt lines on every clock.

// File: rtl/usbdev_irq_pkg.sv
package usbdev_irq_pkg;
   localparam int REG_BITS = 8;

   localparam int B_BUS_RST   = 7;
   localparam int B_BO_FULL   = 6;
   localparam int B_BI_REQ    = 5;
   localparam int B_BI_EMPTY  = 4;
   localparam int B_SETUP     = 3;
   localparam int B_CIN_DONE  = 2;
   localparam int B_COUT_DONE = 1;
   localparam int B_CIN_REQ   = 0;

   // Bits that mirror FIFO state and ignore software writes
   localparam logic [REG_BITS-1:0] STATUS_MASK = 8'h50;

   typedef enum logic [1:0] {
      RA_FLAG   = 2'd0,
      RA_ENABLE = 2'd1,
      RA_SELECT = 2'd2,
      RA_NONE   = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/usbdev_irq_flag_bit.sv
module usbdev_irq_flag_bit #(
   parameter bit IS_STATUS  = 1'b0,
   parameter bit STATUS_REG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic src_i,
   input  logic wr_i,
   input  logic wd_i,
   output logic flag_o
);
   logic q;
   logic nxt;

   // Event bits: a set in the same cycle overrides a write-0 clear
   always_comb begin
      if (IS_STATUS) nxt = src_i;
      else           nxt = src_i | (q & ~(wr_i & ~wd_i));
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= nxt;
   end

   generate
      if (IS_STATUS && !STATUS_REG) begin : g_live
         assign flag_o = rst ? 1'b0 : src_i;
      end else begin : g_reg
         assign flag_o = q;
      end
   endgenerate
endmodule

// File: rtl/usbdev_irq_cfg_regs.sv
module usbdev_irq_cfg_regs
   import usbdev_irq_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wd_i,
   output logic [REG_W-1:0]  en_o,
   output logic [REG_W-1:0]  sel_o
);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(RA_ENABLE);
   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(RA_SELECT);

   always_ff @(posedge clk) begin
      if (rst) begin
         en_o  <= '0;
         sel_o <= '0;
      end else if (wr_i) begin
         if (addr_i == A_EN)  en_o  <= wd_i;
         if (addr_i == A_SEL) sel_o <= wd_i;
      end
   end
endmodule

// File: rtl/usbdev_irq_router.sv
module usbdev_irq_router #(
   parameter int REG_W = 8,
   parameter int N_IRQ = 2
) (
   input  logic [REG_W-1:0] flag_i,
   input  logic [REG_W-1:0] en_i,
   input  logic [REG_W-1:0] sel_i,
   output logic [N_IRQ-1:0] irq_o
);
   logic [REG_W-1:0] armed;
   assign armed = flag_i & en_i;

   generate
      for (genvar k = 0; k < N_IRQ; k++) begin : g_line
         logic [REG_W-1:0] routed;
         if (k == 0) begin : g_l0
            assign routed = ~sel_i;
         end else begin : g_l1
            assign routed = sel_i;
         end
         assign irq_o[k] = |(armed & routed);
      end
   endgenerate
endmodule

// File: rtl/usbdev_irq_flags.sv
module usbdev_irq_flags
   import usbdev_irq_pkg::*;
#(
   parameter int REG_W      = 8,
   parameter int ADDR_W     = 2,
   parameter int N_IRQ      = 2,
   parameter bit STATUS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              usb_bus_reset,
   input  logic              ctl_setup_rcvd,
   input  logic              ctl_in_done,
   input  logic              ctl_out_done,
   input  logic              ctl_in_req,
   input  logic              bulk_in_token,
   input  logic [1:0]        bulk_in_empty,
   input  logic [1:0]        bulk_out_full,
   output logic [N_IRQ-1:0]  irq_out
);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(RA_FLAG);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(RA_ENABLE);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(RA_SELECT);

   generate
      if (REG_W != REG_BITS) begin : g_bad_width
         $error("usbdev_irq_flags: REG_W must equal the fixed flag map width");
      end
      if (N_IRQ != 2) begin : g_bad_lines
         $error("usbdev_irq_flags: one select bit per flag supports two lines");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("usbdev_irq_flags: three registers need at least two address bits");
      end
   endgenerate

   logic [REG_W-1:0] src;
   logic [REG_W-1:0] flag_q;
   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] sel_q;
   logic             flag_wr;
   logic             bi_all_empty;

   assign flag_wr      = reg_wr && (reg_addr == A_FLAG);
   assign bi_all_empty = &bulk_in_empty;

   always_comb begin
      src              = '0;
      src[B_BUS_RST]   = usb_bus_reset;
      src[B_BO_FULL]   = |bulk_out_full;
      src[B_BI_REQ]    = bulk_in_token & bi_all_empty;
      src[B_BI_EMPTY]  = bi_all_empty;
      src[B_SETUP]     = ctl_setup_rcvd;
      src[B_CIN_DONE]  = ctl_in_done;
      src[B_COUT_DONE] = ctl_out_done;
      src[B_CIN_REQ]   = ctl_in_req;
   end

   generate
      for (genvar i = 0; i < REG_W; i++) begin : g_bit
         usbdev_irq_flag_bit #(
            .IS_STATUS (STATUS_MASK[i]),
            .STATUS_REG(STATUS_REG)
         ) u_bit (
            .clk   (clk),
            .rst   (rst),
            .src_i (src[i]),
            .wr_i  (flag_wr),
            .wd_i  (reg_wdata[i]),
            .flag_o(flag_q[i])
         );
      end
   endgenerate

   usbdev_irq_cfg_regs #(
      .REG_W (REG_W),
      .ADDR_W(ADDR_W)
   ) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .wr_i  (reg_wr),
      .addr_i(reg_addr),
      .wd_i  (reg_wdata),
      .en_o  (en_q),
      .sel_o (sel_q)
   );

   usbdev_irq_router #(
      .REG_W(REG_W),
      .N_IRQ(N_IRQ)
   ) u_route (
      .flag_i(flag_q),
      .en_i  (en_q),
      .sel_i (sel_q),
      .irq_o (irq_out)
   );

   always_comb begin
      if (reg_addr == A_FLAG)     reg_rdata = flag_q;
      else if (reg_addr == A_EN)  reg_rdata = en_q;
      else if (reg_addr == A_SEL) reg_rdata = sel_q;
      else                        reg_rdata = '0;
   end
endmodule

// File: rtl/usbdev_irq_flags_chk.sv
module usbdev_irq_flags_chk (
   input logic       clk,
   input logic       rst,
   input logic       reg_wr,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic       usb_bus_reset,
   input logic       ctl_setup_rcvd,
   input logic [1:0] bulk_in_empty,
   input logic [1:0] bulk_out_full,
   input logic [7:0] flags,
   input logic [7:0] en,
   input logic [7:0] sel,
   input logic [1:0] irq
);
   localparam logic [7:0] CLEARABLE = 8'hAF;

   a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (flags == 8'h00 && en == 8'h00 && sel == 8'h00 && irq == 2'b00));

   a_r2_bus_reset_sets: assert property (@(posedge clk) disable iff (rst)
      ($past(usb_bus_reset) && !$past(rst)) |-> flags[7]);

   a_r3_out_full_tracks: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (flags[6] == |$past(bulk_out_full)));

   a_r5_in_empty_tracks: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (flags[4] == &$past(bulk_in_empty)));

   a_r7_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
      ($past(reg_wr && reg_addr == 2'd0) && !$past(rst))
         |-> (($past(flags) & $past(reg_wdata) & CLEARABLE & ~flags) == 8'h00));

   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      ($past(ctl_setup_rcvd) && !$past(rst)) |-> flags[3]);

   a_r11_line0_level: assert property (@(posedge clk) disable iff (rst)
      irq[0] == |(flags & en & ~sel));

   a_r11_line1_level: assert property (@(posedge clk) disable iff (rst)
      irq[1] == |(flags & en & sel));
endmodule

bind usbdev_irq_flags usbdev_irq_flags_chk u_chk (
   .clk           (clk),
   .rst           (rst),
   .reg_wr        (reg_wr),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .usb_bus_reset (usb_bus_reset),
   .ctl_setup_rcvd(ctl_setup_rcvd),
   .bulk_in_empty (bulk_in_empty),
   .bulk_out_full (bulk_out_full),
   .flags         (flag_q),
   .en            (en_q),
   .sel           (sel_q),
   .irq           (irq_out)
);

// File: tb/usbdev_irq_flags_test.sv
module usbdev_irq_flags_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       usb_bus_reset = 1'b0;
   logic       ctl_setup_rcvd = 1'b0;
   logic       ctl_in_done = 1'b0;
   logic       ctl_out_done = 1'b0;
   logic       ctl_in_req = 1'b0;
   logic       bulk_in_token = 1'b0;
   logic [1:0] bulk_in_empty = 2'b00;
   logic [1:0] bulk_out_full = 2'b00;
   logic [1:0] irq_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit go = 1'b0;

   // behavioural reference state
   logic [7:0] m_flag = 8'h00;
   logic [7:0] m_en = 8'h00;
   logic [7:0] m_sel = 8'h00;

   always #10 clk = ~clk;

   usbdev_irq_flags uut (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .usb_bus_reset(usb_bus_reset), .ctl_setup_rcvd(ctl_setup_rcvd),
      .ctl_in_done(ctl_in_done), .ctl_out_done(ctl_out_done),
      .ctl_in_req(ctl_in_req), .bulk_in_token(bulk_in_token),
      .bulk_in_empty(bulk_in_empty), .bulk_out_full(bulk_out_full),
      .irq_out(irq_out)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_flag = 8'h00; m_en = 8'h00; m_sel = 8'h00;
      end else begin
         logic [7:0] nf;
         nf = m_flag;
         if (reg_wr && reg_addr == 2'd0) begin
            for (int b = 0; b < 8; b++)
               if (b != 6 && b != 4 && !reg_wdata[b]) nf[b] = 1'b0;
         end
         if (usb_bus_reset)  nf[7] = 1'b1;
         if (bulk_in_token && bulk_in_empty == 2'b11) nf[5] = 1'b1;
         if (ctl_setup_rcvd) nf[3] = 1'b1;
         if (ctl_in_done)    nf[2] = 1'b1;
         if (ctl_out_done)   nf[1] = 1'b1;
         if (ctl_in_req)     nf[0] = 1'b1;
         nf[6] = (bulk_out_full != 2'b00);
         nf[4] = (bulk_in_empty == 2'b11);
         m_flag = nf;
         if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
         if (reg_wr && reg_addr == 2'd2) m_sel = reg_wdata;
      end
   end

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (go) begin
         logic [7:0] e_rd;
         logic [1:0] e_irq;
         case (reg_addr)
            2'd0: e_rd = m_flag;
            2'd1: e_rd = m_en;
            2'd2: e_rd = m_sel;
            default: e_rd = 8'h00;
         endcase
         e_irq[0] = |(m_flag & m_en & ~m_sel);
         e_irq[1] = |(m_flag & m_en & m_sel);
         checks++;
         if (reg_rdata !== e_rd) begin
            failures++;
            $display("FAIL R10 per-clock readback addr=%0d actual=%h expected=%h", reg_addr, reg_rdata, e_rd);
         end
         checks++;
         if (irq_out !== e_irq) begin
            failures++;
            $display("FAIL R11 per-clock irq actual=%b expected=%b", irq_out, e_irq);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         failures++;
         $display("FAIL R1 watchdog expired actual=%0d expected<=20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] mask,
                         input logic [7:0] exp);
      @(negedge clk);
      #1 reg_addr = a;
      #2 chk(tag, reg_rdata & mask, exp & mask);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic irq_chk(input string tag, input logic [1:0] exp);
      #1 chk(tag, {6'b0, irq_out}, {6'b0, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      go = 1'b1;

      // R1 reset state
      rd_chk("R1 flags", 2'd0, 8'hFF, 8'h00);
      rd_chk("R1 enable", 2'd1, 8'hFF, 8'h00);
      rd_chk("R1 select", 2'd2, 8'hFF, 8'h00);
      irq_chk("R1 irq", 2'b00);

      // R2 bus reset
      @(negedge clk); #1 usb_bus_reset = 1'b1;
      @(negedge clk); #1 usb_bus_reset = 1'b0;
      rd_chk("R2 bus reset flag", 2'd0, 8'hFF, 8'h80);
      irq_chk("R11 disabled stays low", 2'b00);

      // R3 bulk-out full status over buffer patterns
      @(negedge clk); #1 bulk_out_full = 2'b01;
      rd_chk("R3 one full", 2'd0, 8'hFF, 8'hC0);
      @(negedge clk); #1 bulk_out_full = 2'b10;
      rd_chk("R3 other full", 2'd0, 8'h40, 8'h40);
      @(negedge clk); #1 bulk_out_full = 2'b11;
      rd_chk("R3 both full", 2'd0, 8'h40, 8'h40);
      @(negedge clk); #1 bulk_out_full = 2'b00;
      rd_chk("R3 both empty", 2'd0, 8'hFF, 8'h80);

      // R4 / R5 bulk-in request and empty status
      @(negedge clk); #1 bulk_in_empty = 2'b11; bulk_in_token = 1'b1;
      @(negedge clk); #1 bulk_in_token = 1'b0;
      rd_chk("R4 token with both empty", 2'd0, 8'h20, 8'h20);
      rd_chk("R5 both empty", 2'd0, 8'h10, 8'h10);
      wr(2'd0, 8'hDF);
      rd_chk("R7 clear bulk-in request", 2'd0, 8'hFF, 8'h90);
      @(negedge clk); #1 bulk_in_empty = 2'b01; bulk_in_token = 1'b1;
      @(negedge clk); #1 bulk_in_token = 1'b0;
      rd_chk("R4 token with data present", 2'd0, 8'h20, 8'h00);
      rd_chk("R5 one buffer holds data", 2'd0, 8'h10, 8'h00);

      // R6 control and setup events
      @(negedge clk); #1 ctl_setup_rcvd = 1'b1;
      @(negedge clk); #1 ctl_setup_rcvd = 1'b0;
      rd_chk("R6 setup", 2'd0, 8'hFF, 8'h88);
      @(negedge clk); #1 ctl_in_done = 1'b1;
      @(negedge clk); #1 ctl_in_done = 1'b0;
      rd_chk("R6 ctl in done", 2'd0, 8'hFF, 8'h8C);
      @(negedge clk); #1 ctl_out_done = 1'b1;
      @(negedge clk); #1 ctl_out_done = 1'b0;
      rd_chk("R6 ctl out done", 2'd0, 8'hFF, 8'h8E);
      @(negedge clk); #1 ctl_in_req = 1'b1;
      @(negedge clk); #1 ctl_in_req = 1'b0;
      rd_chk("R6 ctl in request", 2'd0, 8'hFF, 8'h8F);

      // R7 write-1 keeps, write-0 clears
      wr(2'd0, 8'hFF);
      rd_chk("R7 write ones no change", 2'd0, 8'hFF, 8'h8F);
      wr(2'd0, 8'h7F);
      rd_chk("R7 write zero clears bit7", 2'd0, 8'hFF, 8'h0F);

      // R8 status bits ignore writes
      @(negedge clk); #1 bulk_out_full = 2'b01; bulk_in_empty = 2'b11;
      rd_chk("R8 status set", 2'd0, 8'hFF, 8'h5F);
      wr(2'd0, 8'h00);
      rd_chk("R8 status survives write 0", 2'd0, 8'h50, 8'h50);
      rd_chk("R7 event bits cleared", 2'd0, 8'hAF, 8'h00);

      // R9 set and clear in one cycle
      @(negedge clk);
      #1 ctl_setup_rcvd = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
      @(negedge clk);
      #1 ctl_setup_rcvd = 1'b0; reg_wr = 1'b0;
      rd_chk("R9 set wins over clear", 2'd0, 8'hFF, 8'h58);

      @(negedge clk); #1 usb_bus_reset = 1'b1;
      @(negedge clk); #1 usb_bus_reset = 1'b0;
      rd_chk("R2 bus reset again", 2'd0, 8'hFF, 8'hD8);

      // R10 enable / select registers
      wr(2'd1, 8'h88);
      wr(2'd2, 8'h08);
      rd_chk("R10 enable readback", 2'd1, 8'hFF, 8'h88);
      rd_chk("R10 select readback", 2'd2, 8'hFF, 8'h08);
      rd_chk("R10 unused address", 2'd3, 8'hFF, 8'h00);

      // R11 routing and level behaviour
      irq_chk("R11 both lines", 2'b11);
      wr(2'd0, 8'hF7);
      irq_chk("R11 line1 drops on clear", 2'b01);
      wr(2'd1, 8'h08);
      irq_chk("R11 line0 drops on disable", 2'b00);
      wr(2'd2, 8'h40);
      wr(2'd1, 8'h40);
      irq_chk("R11 status bit on line1", 2'b10);
      @(negedge clk); #1 bulk_out_full = 2'b00;
      @(negedge clk);
      irq_chk("R11 follows status", 2'b00);

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule